// File: doc/BRIEF.md
# Fully Associative Translation Buffer Array

This block keeps a small set of page-translation entries and answers, in the same cycle, whether a virtual page number seen by a given address-space number has a translation. Every slot can hold any page. A slot stores its virtual page tag, a valid flag, the owning address-space number, a shared flag, a physical page number, one read-enable and one write-enable bit per privilege mode, and two fault-on-access bits (read and write). An entry with the shared flag set matches every address space. The block only stores and matches entries. Address-space policy and permission decisions belong to the logic around it.

The array is written at a round-robin replacement pointer. The surrounding logic can fill the slot under the pointer, look at that slot through a separate read-out port, and step the pointer without writing. There are three invalidation commands: wipe everything, wipe every private (non-shared) entry, and wipe the entries that match the page and address space on the lookup port.

All requests share one command decoder with a fixed priority. Each cycle, exactly one of the named commands is chosen:
- CMD_WIPE_ALL beats CMD_WIPE_PRIVATE.
- CMD_WIPE_PRIVATE beats CMD_WIPE_PAGE.
- CMD_WIPE_PAGE beats CMD_FILL.
- CMD_FILL beats CMD_STEP.
- CMD_STEP beats CMD_IDLE.

The chosen command takes effect at the next clock edge.

Top module: `tlb_assoc_array`

## Requirements
- R1: `lk_hit` is 1 only when some slot is valid, its tag equals `lk_vpn`, and either its shared flag is 1 or its stored address space equals `lk_asn`. When it is 1, `lk_ppn`, `lk_glob`, `lk_rd_en`, `lk_wr_en`, `lk_flt_rd` and `lk_flt_wr` show that slot's fields in the same cycle.
- R2: A fill (CMD_FILL) writes all fields into the slot at the pointer, even if that slot already holds a valid entry, and sets the slot valid. The pointer then advances by one and wraps from DEPTH-1 to 0.
- R3: A wipe-all (CMD_WIPE_ALL) invalidates every slot and returns the pointer to 0.
- R4: A wipe-private (CMD_WIPE_PRIVATE) invalidates every slot whose shared flag is 0. Shared slots stay valid and unchanged, and the pointer does not move.
- R5: A wipe-page (CMD_WIPE_PAGE) invalidates every slot that the R1 rule matches against `lk_vpn`/`lk_asn` in that cycle. Other slots and the pointer are unchanged.
- R6: When several slots match, `lk_idx` names the lowest-numbered one, and the output fields come from that slot.
- R7: Only one command acts per cycle, in the order wipe-all, wipe-private, wipe-page, fill, step. A fill or step that loses to a wipe writes nothing and does not move the pointer.
- R8: `nxt_idx` is the pointer. `nxt_valid`, `nxt_vpn`, `nxt_asn`, `nxt_glob` and `nxt_ppn` show the slot under the pointer. A step (CMD_STEP) advances the pointer with the same wrap as R2 and changes no slot.
- R9: After reset every slot is invalid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vpn | input | VPN_W | Virtual page to look up, and the page for wipe-page |
| lk_asn | input | ASN_W | Current address space for lookup and wipe-page |
| lk_hit | output | 1 | A slot matches |
| lk_idx | output | IDX_W | Index of the winning slot |
| lk_glob | output | 1 | Shared flag of the winning slot |
| lk_ppn | output | PPN_W | Physical page of the winning slot |
| lk_rd_en | output | NMODE | Per-mode read enables of the winning slot |
| lk_wr_en | output | NMODE | Per-mode write enables of the winning slot |
| lk_flt_rd | output | 1 | Fault-on-read bit of the winning slot |
| lk_flt_wr | output | 1 | Fault-on-write bit of the winning slot |
| fill_req | input | 1 | Write a new entry at the pointer |
| fill_vpn | input | VPN_W | Tag for the new entry |
| fill_asn | input | ASN_W | Address space for the new entry |
| fill_glob | input | 1 | Shared flag for the new entry |
| fill_ppn | input | PPN_W | Physical page for the new entry |
| fill_rd_en | input | NMODE | Read enables for the new entry |
| fill_wr_en | input | NMODE | Write enables for the new entry |
| fill_flt_rd | input | 1 | Fault-on-read bit for the new entry |
| fill_flt_wr | input | 1 | Fault-on-write bit for the new entry |
| wipe_all_req | input | 1 | Invalidate all slots and reset the pointer |
| wipe_private_req | input | 1 | Invalidate all non-shared slots |
| wipe_page_req | input | 1 | Invalidate slots matching the lookup port |
| step_req | input | 1 | Advance the pointer without writing |
| nxt_idx | output | IDX_W | Replacement pointer |
| nxt_valid | output | 1 | Valid flag of the slot under the pointer |
| nxt_vpn | output | VPN_W | Tag of the slot under the pointer |
| nxt_asn | output | ASN_W | Address space of the slot under the pointer |
| nxt_glob | output | 1 | Shared flag of the slot under the pointer |
| nxt_ppn | output | PPN_W | Physical page of the slot under the pointer |

## Verification
A fill and a wipe can be requested in the same cycle. In that case the wipe wins and the fill must leave no trace, neither in the array nor in the pointer. The bench provokes this on purpose with each of the three wipes paired with a fill, and with wipe-private paired with a step. A random phase then raises all request lines independently. After every such cycle, the pointer, the slot under the pointer and the lookup result are compared with a behavioural model that applies the priority order. Any written slot or stray pointer step therefore shows up as a mismatch.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W = 13;
    parameter int ASN_W = 7;
    parameter int PPN_W = 16;
    parameter int NMODE = 4;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [PPN_W-1:0] ppn;
        logic [NMODE-1:0] rd_en;
        logic [NMODE-1:0] wr_en;
        logic             flt_rd;
        logic             flt_wr;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_WIPE_ALL,
        CMD_WIPE_PRIVATE,
        CMD_WIPE_PAGE,
        CMD_FILL,
        CMD_STEP
    } tlb_cmd_e;
endpackage

// File: rtl/tlb_cmd_sel.sv
module tlb_cmd_sel
    import tlb_pkg::*;
(
    input  logic     wipe_all_req,
    input  logic     wipe_private_req,
    input  logic     wipe_page_req,
    input  logic     fill_req,
    input  logic     step_req,
    output tlb_cmd_e cmd
);
    // Fixed priority; R7
    always_comb begin
        if (wipe_all_req)          cmd = CMD_WIPE_ALL;
        else if (wipe_private_req) cmd = CMD_WIPE_PRIVATE;
        else if (wipe_page_req)    cmd = CMD_WIPE_PAGE;
        else if (fill_req)         cmd = CMD_FILL;
        else if (step_req)         cmd = CMD_STEP;
        else                       cmd = CMD_IDLE;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  tlb_entry_t       tbl [DEPTH],
    input  logic [VPN_W-1:0] vpn,
    input  logic [ASN_W-1:0] asn,
    output logic [DEPTH-1:0] hit_vec
);
    // One comparator per slot; R1 rule
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = tbl[g].valid && (tbl[g].vpn == vpn) &&
                            (tbl[g].glob || (tbl[g].asn == asn));
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int DEPTH = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] sel_vec,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any
);
    // Lowest index wins; R6
    always_comb begin
        sel_idx = '0;
        sel_vec = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = IDX_W'(i);
                sel_vec = '0;
                sel_vec[i] = 1'b1;
            end
        end
    end
    assign any = |hit_vec;

    a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec) && (any == (sel_vec != '0)));
    a_r6_winner_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (hit_vec[sel_idx] && ((hit_vec & ((DEPTH'(1) << sel_idx) - DEPTH'(1))) == '0)));
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int DEPTH = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr <= '0;
        else if (clear)    ptr <= '0;
        else if (advance)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
    a_r2_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && ptr == LAST) |=> ptr == '0);
    a_r3_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ptr == '0);
endmodule

// File: rtl/tlb_assoc_array.sv
module tlb_assoc_array
    import tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic             lk_glob,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [NMODE-1:0] lk_rd_en,
    output logic [NMODE-1:0] lk_wr_en,
    output logic             lk_flt_rd,
    output logic             lk_flt_wr,
    input  logic             fill_req,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic             fill_glob,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [NMODE-1:0] fill_rd_en,
    input  logic [NMODE-1:0] fill_wr_en,
    input  logic             fill_flt_rd,
    input  logic             fill_flt_wr,
    input  logic             wipe_all_req,
    input  logic             wipe_private_req,
    input  logic             wipe_page_req,
    input  logic             step_req,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             nxt_valid,
    output logic [VPN_W-1:0] nxt_vpn,
    output logic [ASN_W-1:0] nxt_asn,
    output logic             nxt_glob,
    output logic [PPN_W-1:0] nxt_ppn
);
    tlb_entry_t       tbl [DEPTH];
    tlb_cmd_e         cmd;
    logic [DEPTH-1:0] hit_vec, sel_vec, valid_vec, glob_vec;
    logic [IDX_W-1:0] ptr;
    tlb_entry_t       win, cur, fresh;

    tlb_cmd_sel u_cmd (
        .wipe_all_req    (wipe_all_req),
        .wipe_private_req(wipe_private_req),
        .wipe_page_req   (wipe_page_req),
        .fill_req        (fill_req),
        .step_req        (step_req),
        .cmd             (cmd)
    );

    tlb_match #(.DEPTH(DEPTH)) u_match (
        .tbl(tbl), .vpn(lk_vpn), .asn(lk_asn), .hit_vec(hit_vec)
    );

    tlb_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec),
        .sel_vec(sel_vec), .sel_idx(lk_idx), .any(lk_hit)
    );

    tlb_rr_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cmd == CMD_WIPE_ALL),
        .advance((cmd == CMD_FILL) || (cmd == CMD_STEP)),
        .ptr    (ptr)
    );

    always_comb begin
        fresh        = '0;
        fresh.valid  = 1'b1;
        fresh.vpn    = fill_vpn;
        fresh.asn    = fill_asn;
        fresh.glob   = fill_glob;
        fresh.ppn    = fill_ppn;
        fresh.rd_en  = fill_rd_en;
        fresh.wr_en  = fill_wr_en;
        fresh.flt_rd = fill_flt_rd;
        fresh.flt_wr = fill_flt_wr;
    end

    // Array update, one command per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else begin
            unique case (cmd)
                CMD_WIPE_ALL:
                    for (int i = 0; i < DEPTH; i++) tbl[i].valid <= 1'b0;
                CMD_WIPE_PRIVATE:
                    for (int i = 0; i < DEPTH; i++)
                        if (!tbl[i].glob) tbl[i].valid <= 1'b0;
                CMD_WIPE_PAGE:
                    for (int i = 0; i < DEPTH; i++)
                        if (hit_vec[i]) tbl[i].valid <= 1'b0;
                CMD_FILL:
                    tbl[ptr] <= fresh;
                CMD_STEP, CMD_IDLE: ;
                default: ;
            endcase
        end
    end

    // Output process
    always_comb begin
        win = lk_hit ? tbl[lk_idx] : '0;
        cur = tbl[ptr];
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i] = tbl[i].valid;
            glob_vec[i]  = tbl[i].glob;
        end
    end

    assign lk_glob   = win.glob;
    assign lk_ppn    = win.ppn;
    assign lk_rd_en  = win.rd_en;
    assign lk_wr_en  = win.wr_en;
    assign lk_flt_rd = win.flt_rd;
    assign lk_flt_wr = win.flt_wr;
    assign nxt_idx   = ptr;
    assign nxt_valid = cur.valid;
    assign nxt_vpn   = cur.vpn;
    assign nxt_asn   = cur.asn;
    assign nxt_glob  = cur.glob;
    assign nxt_ppn   = cur.ppn;

    a_r3_all_gone: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_all_req |=> (valid_vec == '0) && (nxt_idx == '0));
    a_r4_shared_survive: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WIPE_PRIVATE) |=>
            (valid_vec == $past(valid_vec & glob_vec)) && $stable(ptr));
    a_r5_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WIPE_PAGE) |=>
            ((valid_vec & $past(hit_vec)) == '0) &&
            (valid_vec == ($past(valid_vec) & ~$past(hit_vec))));
    a_r2_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FILL) |=> valid_vec[$past(ptr)] && (tbl[$past(ptr)].vpn == $past(fill_vpn)));
    a_r8_step_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP) |=> $stable(valid_vec));
    a_r7_wipe_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && (wipe_private_req || wipe_page_req) && !wipe_all_req) |=> $stable(ptr));
    a_r1_hit_fields: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (sel_vec[lk_idx] && (lk_ppn == tbl[lk_idx].ppn)));
endmodule

// File: tb/test_tlb_assoc_array.sv
module test_tlb_assoc_array;
    import tlb_pkg::*;
    localparam int DEPTH = 48;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic lk_hit, lk_glob, lk_flt_rd, lk_flt_wr;
    logic [IDX_W-1:0] lk_idx, nxt_idx;
    logic [PPN_W-1:0] lk_ppn, nxt_ppn;
    logic [NMODE-1:0] lk_rd_en, lk_wr_en;
    logic fill_req = 0, fill_glob = 0, fill_flt_rd = 0, fill_flt_wr = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ASN_W-1:0] fill_asn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [NMODE-1:0] fill_rd_en = '0, fill_wr_en = '0;
    logic wipe_all_req = 0, wipe_private_req = 0, wipe_page_req = 0, step_req = 0;
    logic nxt_valid, nxt_glob;
    logic [VPN_W-1:0] nxt_vpn;
    logic [ASN_W-1:0] nxt_asn;

    tlb_assoc_array #(.DEPTH(DEPTH)) i_tlb_assoc_array (.*);

    // Behavioural reference model
    int m_valid [DEPTH];
    int m_vpn   [DEPTH];
    int m_asn   [DEPTH];
    int m_glob  [DEPTH];
    int m_ppn   [DEPTH];
    int m_attr  [DEPTH];
    int m_ptr;
    int vectors = 0;
    int errors  = 0;
    bit done = 0;

    function automatic int ref_find();
        for (int i = 0; i < DEPTH; i++)
            if (m_valid[i] != 0 && m_vpn[i] == int'(lk_vpn) &&
                (m_glob[i] != 0 || m_asn[i] == int'(lk_asn)))
                return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_vpn[i] = 0; m_asn[i] = 0;
            m_glob[i] = 0; m_ppn[i] = 0; m_attr[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic model_commit();
        if (wipe_all_req) begin
            for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
            m_ptr = 0;
        end else if (wipe_private_req) begin
            for (int i = 0; i < DEPTH; i++) if (m_glob[i] == 0) m_valid[i] = 0;
        end else if (wipe_page_req) begin
            for (int i = 0; i < DEPTH; i++)
                if (m_valid[i] != 0 && m_vpn[i] == int'(lk_vpn) &&
                    (m_glob[i] != 0 || m_asn[i] == int'(lk_asn)))
                    m_valid[i] = 0;
        end else if (fill_req) begin
            m_valid[m_ptr] = 1;
            m_vpn[m_ptr]   = int'(fill_vpn);
            m_asn[m_ptr]   = int'(fill_asn);
            m_glob[m_ptr]  = int'(fill_glob);
            m_ppn[m_ptr]   = int'(fill_ppn);
            m_attr[m_ptr]  = int'({fill_rd_en, fill_wr_en, fill_flt_rd, fill_flt_wr});
            m_ptr = (m_ptr + 1) % DEPTH;
        end else if (step_req) begin
            m_ptr = (m_ptr + 1) % DEPTH;
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        int w;
        w = ref_find();
        check(req, "lk_hit", int'(lk_hit), int'(w >= 0));
        if (w >= 0) begin
            check(req, "lk_idx", int'(lk_idx), w);
            check(req, "lk_ppn", int'(lk_ppn), m_ppn[w]);
            check(req, "lk_glob", int'(lk_glob), m_glob[w]);
            check(req, "lk_attr", int'({lk_rd_en, lk_wr_en, lk_flt_rd, lk_flt_wr}), m_attr[w]);
        end
        check(req, "nxt_idx", int'(nxt_idx), m_ptr);
        check(req, "nxt_valid", int'(nxt_valid), m_valid[m_ptr]);
        if (m_valid[m_ptr] != 0) begin
            check(req, "nxt_vpn", int'(nxt_vpn), m_vpn[m_ptr]);
            check(req, "nxt_asn", int'(nxt_asn), m_asn[m_ptr]);
            check(req, "nxt_ppn", int'(nxt_ppn), m_ppn[m_ptr]);
        end
    endtask

    // One cycle: compare mid-cycle, then commit at the edge and drop requests
    task automatic tick(string req);
        @(negedge clk);
        compare(req);
        @(posedge clk);
        if (rst_n) model_commit();
        #1;
        fill_req = 0; wipe_all_req = 0; wipe_private_req = 0;
        wipe_page_req = 0; step_req = 0;
    endtask

    task automatic set_fill(int vpn, int asn, int g, int ppn);
        fill_req = 1; fill_vpn = VPN_W'(vpn); fill_asn = ASN_W'(asn);
        fill_glob = g[0]; fill_ppn = PPN_W'(ppn);
        fill_rd_en = NMODE'(ppn); fill_wr_en = NMODE'(ppn >> 4);
        fill_flt_rd = ppn[1]; fill_flt_wr = ppn[2];
    endtask

    task automatic look(int vpn, int asn);
        lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
    endtask

    initial begin
        model_reset();
        repeat (2) tick("R9 reset");
        rst_n = 1'b1;
        tick("R9 reset state");

        // R2 fills, then R1 lookups with address-space and shared rules
        set_fill(5, 1, 0, 'h100); tick("R2 fill");
        set_fill(5, 2, 0, 'h200); tick("R2 fill");
        set_fill(7, 3, 1, 'h300); tick("R2 fill");
        look(5, 1); tick("R1 own asn");
        look(5, 2); tick("R1 other asn");
        look(5, 3); tick("R1 miss asn");
        look(7, 9); tick("R1 shared any asn");
        look(9, 1); tick("R1 miss vpn");

        // R6 duplicate match, lowest index wins
        set_fill(5, 1, 0, 'h4a5); tick("R6 dup fill");
        look(5, 1); tick("R6 lowest wins");

        // R5 wipe-page removes both copies, spares the other space
        look(5, 1); wipe_page_req = 1; tick("R5 wipe page");
        look(5, 1); tick("R5 gone");
        look(5, 2); tick("R5 other kept");

        // R4 wipe-private spares the shared entry
        wipe_private_req = 1; tick("R4 wipe private");
        look(7, 4); tick("R4 shared kept");
        look(5, 2); tick("R4 private gone");

        // R8 step and read-out
        step_req = 1; tick("R8 step");
        step_req = 1; tick("R8 step");
        tick("R8 read-out");

        // R2 wrap through all slots, overwriting
        for (int i = 0; i < DEPTH + 6; i++) begin
            set_fill(100 + i, i % 5, int'(i % 7 == 0), 'h1000 + i);
            look(100 + i - 1, (i - 1) % 5);
            tick("R2 wrap fill");
        end
        look(7, 4); tick("R2 overwritten");

        // R7 collisions: every wipe against a fill, plus wipe against step
        look(110, 0); wipe_page_req = 1; set_fill(300, 1, 0, 'h55); tick("R7 page beats fill");
        look(300, 1); tick("R7 fill dropped");
        wipe_private_req = 1; set_fill(301, 1, 0, 'h56); tick("R7 private beats fill");
        wipe_private_req = 1; step_req = 1; tick("R7 private beats step");
        look(301, 1); tick("R7 fill dropped");
        wipe_all_req = 1; set_fill(302, 1, 1, 'h57); tick("R7 all beats fill");
        look(302, 1); tick("R3 empty after wipe-all");

        // R3 wipe-all after refill
        set_fill(12, 2, 1, 'h77); tick("R3 refill");
        wipe_all_req = 1; tick("R3 wipe all");
        look(12, 2); tick("R3 cleared");

        // Random mix of all commands, small page range for collisions
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            look(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
            if (r < 45) set_fill(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                                 int'($urandom_range(0, 3) == 0), int'($urandom_range(0, 65535)));
            step_req = ($urandom_range(0, 9) == 0);
            wipe_page_req = ($urandom_range(0, 11) == 0);
            wipe_private_req = ($urandom_range(0, 39) == 0);
            wipe_all_req = ($urandom_range(0, 199) == 0);
            tick("R7 random mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule